// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command bus of one SDRAM rank. Out of reset it keeps the bus idle for a programmed number of clocks. It then closes every bank with a precharge-all and issues a programmed run of auto-refresh commands. It finishes the start-up by loading the mode register. Once the settle gap after that load has passed, it raises `ready`. From then on an interval counter asks for one auto-refresh per interval. The interval is the retention period divided by the row count, converted to clocks.

A user controller shares the bus through `usr_req` and `usr_grant`. While it holds the grant, the command fields it presents are registered and driven onto the bus one clock later. A refresh that falls due during a grant waits until the user drops its request. Such refreshes are counted, up to a parameter limit. When the bus comes free they are issued back to back. If the user reports an open bank through `bank_open`, a precharge-all goes out first.

All timing values (idle wait, precharge time, refresh cycle time, mode-load gap, refresh interval) are whole clock counts given as parameters.

Top module: `sdr_init_refresh`

## Requirements
- R1: While `rst` is high, the bus carries NOP and `sd_cke`, `ready` and `usr_grant` are low. From the first cycle after reset release, `sd_cke` is high.
- R2: Commands are encoded as {cs_n,ras_n,cas_n,we_n}: NOP=0111, precharge=0010, auto-refresh=0001, mode load=0000. After reset release the bus shows NOP for exactly INIT_WAIT_CYC cycles. The next command is a precharge with address bit AP_BIT (10) set, which closes all banks.
- R3: Exactly INIT_REFS start-up auto-refresh commands follow. The first comes T_RP cycles after the precharge, and each further one comes T_RC cycles after the previous one.
- R4: The mode load comes T_RC cycles after the last start-up refresh, with `sd_addr` equal to MODE_WORD and `sd_ba` zero.
- R5: `ready` rises T_RSC cycles after the mode load and stays high until the next reset.
- R6: The first periodic auto-refresh appears REF_INTERVAL_CYC+1 cycles after `ready` rises. After that, periodic refreshes come every REF_INTERVAL_CYC cycles while the user is not holding the bus.
- R7: With `ready` high and no refresh owed, `usr_grant` rises one cycle after `usr_req`. A user command presented while both are high appears on the bus one cycle later. User command fields are ignored while not granted.
- R8: No auto-refresh is issued while `usr_grant` is high. `usr_grant` falls one cycle after `usr_req` falls.
- R9: Refreshes that fall due during a grant are counted, saturating at MAX_POSTPONE. After the grant ends, exactly that many auto-refresh commands are issued.
- R10: If `bank_open` is high when a refresh burst starts, a precharge-all (bit 10 set) is issued first, and the refresh follows T_RP cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usr_req | input | 1 | User asks for the command bus |
| usr_grant | output | 1 | Bus handed to the user |
| usr_cs_n | input | 1 | User chip select |
| usr_ras_n | input | 1 | User row strobe |
| usr_cas_n | input | 1 | User column strobe |
| usr_we_n | input | 1 | User write enable |
| usr_addr | input | ADDR_W | User address |
| usr_ba | input | BA_W | User bank address |
| bank_open | input | 1 | User reports at least one open bank |
| sd_cke | output | 1 | Clock enable to the SDRAM |
| sd_cs_n | output | 1 | Chip select to the SDRAM |
| sd_ras_n | output | 1 | Row strobe to the SDRAM |
| sd_cas_n | output | 1 | Column strobe to the SDRAM |
| sd_we_n | output | 1 | Write enable to the SDRAM |
| sd_addr | output | ADDR_W | Address to the SDRAM |
| sd_ba | output | BA_W | Bank address to the SDRAM |
| ready | output | 1 | Start-up sequence complete |

## Verification
The bench checks the exact clock on which each start-up command lands. A gap counter that is off by one would shift the precharge, the refreshes or the mode load by one slot, and `ready` would rise a cycle early. It holds the grant across four refresh intervals with a bank reported open. A scheduler that drops owed refreshes, that does not saturate, or that refreshes under the grant shows up as the wrong number of refresh commands after release, as a missing precharge-all, or as a refresh seen while granted. A reset in mid-operation must bring the whole start-up sequence back.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_MRS = 4'b0000;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_NOP = 4'b0111;

  typedef enum logic [1:0] {ST_WAIT, ST_GAP, ST_RUN} seq_st_t;
  typedef enum logic [2:0] {NX_INIT_REF, NX_MRS, NX_READY, NX_RUN_REF, NX_RUN} seq_nx_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdr_ref_sched.sv
module sdr_ref_sched #(
  parameter int unsigned INTERVAL_CYC = 1560,
  parameter int unsigned MAX_POSTPONE = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic done,
  output logic pending
);
  localparam int IW = $clog2(INTERVAL_CYC + 1);
  localparam int DW = $clog2(MAX_POSTPONE + 1);
  localparam logic [IW-1:0] RELOAD = IW'(INTERVAL_CYC - 1);
  localparam logic [DW-1:0] DMAX   = DW'(MAX_POSTPONE);

  logic          running;
  logic [IW-1:0] ivl_cnt;
  logic [DW-1:0] debt;
  logic          tick;

  assign tick    = running && (ivl_cnt == '0);
  assign pending = (debt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      ivl_cnt <= '0;
    end else if (start) begin
      running <= 1'b1;
      ivl_cnt <= RELOAD;
    end else if (running) begin
      ivl_cnt <= tick ? RELOAD : ivl_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      debt <= '0;
    end else begin
      case ({tick, done})
        2'b10:   if (debt != DMAX) debt <= debt + 1'b1;
        2'b01:   if (debt != '0)   debt <= debt - 1'b1;
        default: debt <= debt;
      endcase
    end
  end

  p_debt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    debt <= DMAX);
  p_done_needs_debt_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> pending);
  p_tick_adds_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && !done && debt != DMAX) |=> debt == $past(debt) + 1'b1);
endmodule

// File: rtl/sdr_cmd_fsm.sv
module sdr_cmd_fsm
  import sdr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned BA_W          = 2,
  parameter int unsigned INIT_WAIT_CYC = 10000,
  parameter int unsigned INIT_REFS     = 8,
  parameter int unsigned T_RP          = 2,
  parameter int unsigned T_RC          = 7,
  parameter int unsigned T_RSC         = 2,
  parameter int unsigned AP_BIT        = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = 'h032
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pending,
  input  logic              bank_open,
  input  logic              usr_req,
  input  logic [3:0]        usr_cmd,
  input  logic [ADDR_W-1:0] usr_addr,
  input  logic [BA_W-1:0]   usr_ba,
  output logic              sched_start,
  output logic              ref_done,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              cke_o,
  output logic              ready_o,
  output logic              grant_o
);
  localparam int MAXD  = max2(max2(INIT_WAIT_CYC, T_RC), max2(T_RP, T_RSC));
  localparam int CNT_W = $clog2(MAXD + 1);
  localparam int RW    = $clog2(INIT_REFS + 1);

  seq_st_t          st;
  seq_nx_t          nx;
  logic [CNT_W-1:0] cnt;
  logic [RW-1:0]    refs_left;
  logic             gap_done, run_free;

  assign gap_done    = (st == ST_GAP) && (cnt == '0);
  assign run_free    = (st == ST_RUN) && !grant_o && pending;
  assign sched_start = gap_done && (nx == NX_READY);
  assign ref_done    = (run_free && !bank_open) || (gap_done && nx == NX_RUN_REF);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_WAIT;
      nx        <= NX_INIT_REF;
      cnt       <= CNT_W'(INIT_WAIT_CYC - 1);
      refs_left <= RW'(INIT_REFS);
      cmd_o     <= CMD_NOP;
      addr_o    <= '0;
      ba_o      <= '0;
      cke_o     <= 1'b0;
      ready_o   <= 1'b0;
      grant_o   <= 1'b0;
    end else begin
      cke_o  <= 1'b1;
      cmd_o  <= CMD_NOP;
      addr_o <= '0;
      ba_o   <= '0;
      case (st)
        ST_WAIT: begin
          if (cnt == '0) begin
            cmd_o          <= CMD_PRE;
            addr_o[AP_BIT] <= 1'b1;
            cnt            <= CNT_W'(T_RP - 1);
            nx             <= NX_INIT_REF;
            st             <= ST_GAP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            case (nx)
              NX_INIT_REF: begin
                cmd_o     <= CMD_REF;
                cnt       <= CNT_W'(T_RC - 1);
                refs_left <= refs_left - 1'b1;
                nx        <= (refs_left == RW'(1)) ? NX_MRS : NX_INIT_REF;
              end
              NX_MRS: begin
                cmd_o  <= CMD_MRS;
                addr_o <= MODE_WORD;
                cnt    <= CNT_W'(T_RSC - 1);
                nx     <= NX_READY;
              end
              NX_READY: begin
                ready_o <= 1'b1;
                st      <= ST_RUN;
              end
              NX_RUN_REF: begin
                cmd_o <= CMD_REF;
                cnt   <= CNT_W'(T_RC - 1);
                nx    <= NX_RUN;
              end
              default: st <= ST_RUN;
            endcase
          end
        end
        default: begin
          if (grant_o) begin
            if (usr_req) begin
              cmd_o  <= usr_cmd;
              addr_o <= usr_addr;
              ba_o   <= usr_ba;
            end else begin
              grant_o <= 1'b0;
            end
          end else if (pending) begin
            st <= ST_GAP;
            if (bank_open) begin
              cmd_o          <= CMD_PRE;
              addr_o[AP_BIT] <= 1'b1;
              cnt            <= CNT_W'(T_RP - 1);
              nx             <= NX_RUN_REF;
            end else begin
              cmd_o <= CMD_REF;
              cnt   <= CNT_W'(T_RC - 1);
              nx    <= NX_RUN;
            end
          end else if (usr_req) begin
            grant_o <= 1'b1;
          end
        end
      endcase
    end
  end

  // cycles since the last refresh on the bus, for the spacing check
  logic [CNT_W-1:0] since_ref;
  logic             ref_seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      since_ref <= '0;
      ref_seen  <= 1'b0;
    end else if (cmd_o == CMD_REF) begin
      since_ref <= '0;
      ref_seen  <= 1'b1;
    end else if (since_ref != CNT_W'(T_RC)) begin
      since_ref <= since_ref + 1'b1;
    end
  end

  p_ref_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_REF && ref_seen) |-> since_ref >= CNT_W'(T_RC - 1));
  p_ready_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o);
  p_no_grant_early_r7: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> !grant_o);
  p_no_ref_granted_r8: assert property (@(posedge clk) disable iff (rst)
    grant_o |=> cmd_o != CMD_REF);
endmodule

// File: rtl/sdr_init_refresh.sv
module sdr_init_refresh
  import sdr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W           = 12,
  parameter int unsigned BA_W             = 2,
  parameter int unsigned INIT_WAIT_CYC    = 10000,
  parameter int unsigned INIT_REFS        = 8,
  parameter int unsigned T_RP             = 2,
  parameter int unsigned T_RC             = 7,
  parameter int unsigned T_RSC            = 2,
  parameter int unsigned REF_INTERVAL_CYC = 1560,
  parameter int unsigned MAX_POSTPONE     = 8,
  parameter int unsigned AP_BIT           = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD  = 'h032
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              usr_req,
  output logic              usr_grant,
  input  logic              usr_cs_n,
  input  logic              usr_ras_n,
  input  logic              usr_cas_n,
  input  logic              usr_we_n,
  input  logic [ADDR_W-1:0] usr_addr,
  input  logic [BA_W-1:0]   usr_ba,
  input  logic              bank_open,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              ready
);
  logic       pending, sched_start, ref_done;
  logic [3:0] cmd;

  sdr_ref_sched #(
    .INTERVAL_CYC (REF_INTERVAL_CYC),
    .MAX_POSTPONE (MAX_POSTPONE)
  ) u_sched (
    .clk     (clk),
    .rst     (rst),
    .start   (sched_start),
    .done    (ref_done),
    .pending (pending)
  );

  sdr_cmd_fsm #(
    .ADDR_W        (ADDR_W),
    .BA_W          (BA_W),
    .INIT_WAIT_CYC (INIT_WAIT_CYC),
    .INIT_REFS     (INIT_REFS),
    .T_RP          (T_RP),
    .T_RC          (T_RC),
    .T_RSC         (T_RSC),
    .AP_BIT        (AP_BIT),
    .MODE_WORD     (MODE_WORD)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .pending     (pending),
    .bank_open   (bank_open),
    .usr_req     (usr_req),
    .usr_cmd     ({usr_cs_n, usr_ras_n, usr_cas_n, usr_we_n}),
    .usr_addr    (usr_addr),
    .usr_ba      (usr_ba),
    .sched_start (sched_start),
    .ref_done    (ref_done),
    .cmd_o       (cmd),
    .addr_o      (sd_addr),
    .ba_o        (sd_ba),
    .cke_o       (sd_cke),
    .ready_o     (ready),
    .grant_o     (usr_grant)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
endmodule

// File: tb/sdr_init_refresh_tb.sv
module sdr_init_refresh_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 20;
  localparam int IVL = 40;
  localparam int NREF = 3;
  localparam int TRP = 2;
  localparam int TRC = 4;
  localparam int TRSC = 3;
  localparam int MAXP = 3;
  localparam logic [11:0] MODE = 12'h023;
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000, C_ACT = 4'b0011;
  localparam int RDY_S = W + TRP + (NREF - 1) * TRC + TRC + TRSC;
  // {sample index, expected command}
  localparam logic [13:0] VEC [7] = '{
    {10'(W), C_PRE},
    {10'(W + TRP), C_REF},
    {10'(W + TRP + TRC), C_REF},
    {10'(W + TRP + 2 * TRC), C_REF},
    {10'(W + TRP + 3 * TRC), C_MRS},
    {10'(RDY_S + IVL + 1), C_REF},
    {10'(RDY_S + 2 * IVL + 1), C_REF}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic usr_req = 1'b0, bank_open = 1'b0;
  logic [3:0] ucmd = C_NOP;
  logic [11:0] uaddr = '0;
  logic [1:0] uba = '0;
  logic usr_grant, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, ready;
  logic [11:0] sd_addr;
  logic [1:0] sd_ba;
  wire [3:0] bus = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  int n_vec = 0, n_bad = 0, s = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdr_init_refresh #(
    .ADDR_W(12), .BA_W(2), .INIT_WAIT_CYC(W), .INIT_REFS(NREF), .T_RP(TRP),
    .T_RC(TRC), .T_RSC(TRSC), .REF_INTERVAL_CYC(IVL), .MAX_POSTPONE(MAXP),
    .AP_BIT(10), .MODE_WORD(MODE)
  ) u_dut (
    .clk(clk), .rst(rst), .usr_req(usr_req), .usr_grant(usr_grant),
    .usr_cs_n(ucmd[3]), .usr_ras_n(ucmd[2]), .usr_cas_n(ucmd[1]), .usr_we_n(ucmd[0]),
    .usr_addr(uaddr), .usr_ba(uba), .bank_open(bank_open), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_ba(sd_ba), .ready(ready)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at sample %0d: actual=%0h expected=%0h", tag, s, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    s++;
  endtask

  task automatic goto(input int t);
    while (s < t) step();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n_pre, n_ref;
    repeat (3) @(negedge clk);
    // R1: values during reset
    chk("R1 bus in reset", bus, C_NOP);
    chk("R1 cke in reset", sd_cke, 0);
    chk("R1 ready in reset", ready, 0);
    chk("R1 grant in reset", usr_grant, 0);
    rst = 1'b0;
    s = 0;
    // table walk over start-up and first periodic refreshes
    for (int t = 0; t <= RDY_S + 2 * IVL + 2; t++) begin
      logic [3:0] exp;
      string tag;
      goto(t);
      exp = C_NOP;
      tag = "R2 idle";
      for (int k = 0; k < 7; k++) begin
        if (int'(VEC[k][13:4]) == t) begin
          exp = VEC[k][3:0];
          tag = (exp == C_PRE) ? "R2 precharge" : (exp == C_MRS) ? "R4 mode load" :
                (t > RDY_S) ? "R6 periodic refresh" : "R3 init refresh";
        end
      end
      chk(tag, bus, exp);
      chk("R5 ready", ready, (t >= RDY_S) ? 1 : 0);
      if (exp == C_PRE) chk("R2 A10 on precharge", sd_addr[10], 1);
      if (exp == C_MRS) begin
        chk("R4 mode word", sd_addr, MODE);
        chk("R4 mode bank", sd_ba, 0);
      end
      if (t == 1) chk("R1 cke after reset", sd_cke, 1);
    end

    // R7: user fields ignored without grant
    goto(121);
    ucmd = C_ACT; uaddr = 12'h5A5; uba = 2'd2;
    for (int t = 123; t <= 125; t++) begin
      goto(t);
      chk("R7 ignored when not granted", bus, C_NOP);
    end
    usr_req = 1'b1; bank_open = 1'b1;
    step(); // 126
    chk("R7 grant one cycle after req", usr_grant, 1);
    chk("R7 bus before forward", bus, C_NOP);
    step(); // 127
    chk("R7 forwarded command", bus, C_ACT);
    chk("R7 forwarded addr", sd_addr, 12'h5A5);
    chk("R7 forwarded bank", sd_ba, 2);
    ucmd = C_NOP; uaddr = '0; uba = '0;
    // R8: hold grant across four refresh intervals
    n_ref = 0;
    while (s < 278) begin
      step();
      if (bus == C_REF) n_ref++;
      if (usr_grant != 1'b1) chk("R8 grant held", usr_grant, 1);
    end
    chk("R8 no refresh while granted", n_ref, 0);
    usr_req = 1'b0;
    step(); // 279
    chk("R8 grant falls after req", usr_grant, 0);
    chk("R8 bus after release", bus, C_NOP);
    step(); // 280
    chk("R10 precharge-all first", bus, C_PRE);
    chk("R10 A10 set", sd_addr[10], 1);
    bank_open = 1'b0;
    n_pre = 0; n_ref = 0;
    step(); // 281
    chk("R10 refresh after T_RP not before", bus, C_NOP);
    step(); // 282
    chk("R10 refresh T_RP after precharge", bus, C_REF);
    n_ref = 1;
    while (s < 315) begin
      step();
      if (bus == C_REF) n_ref++;
      if (bus == C_PRE) n_pre++;
    end
    chk("R9 saturated postponed refreshes", n_ref, MAXP);
    chk("R10 single precharge", n_pre, 0);
    goto(2 + 76 + 5 * IVL + 40); // 318
    chk("R6 cadence resumes", bus, C_REF);

    // R1/R2: reset in mid-operation restarts the sequence
    goto(320);
    rst = 1'b1;
    step();
    chk("R1 ready cleared by reset", ready, 0);
    chk("R1 cke cleared by reset", sd_cke, 0);
    chk("R1 bus nop in reset", bus, C_NOP);
    step();
    rst = 1'b0;
    s = 0;
    n_ref = 0;
    while (s < W - 1) begin
      step();
      if (bus != C_NOP) n_ref++;
    end
    chk("R2 idle after re-reset", n_ref, 0);
    step();
    chk("R2 precharge after re-reset", bus, C_PRE);
    chk("R5 ready low during restart", ready, 0);
    finish_run();
  end
endmodule